// File: doc/BRIEF.md
# Image Sensor Black Level Clamp

This block sits in the raw pixel path right after the sensor's analog-to-digital converter. Each sensor line starts with a group of optically shielded pixels, and their value shows the dark offset of the sensor. The block counts the valid pixels of every line. It accumulates a configurable run of 8 or 16 of these shielded pixels and divides the sum by a shift to get a black level. It then subtracts that level from every pixel it forwards, and a result that would go negative is held at zero.

A static configuration input can replace the measured level with a programmed constant. The measurement keeps running in the background, so switching back to measured mode takes effect at once. The output is the corrected pixel together with copies of the valid and sync strobes, all delayed by exactly one clock.

Top module: `pix_black_clamp`

## Requirements
- R1: Every output (`out_valid`, `out_line_sync`, `out_frame_sync`, `out_pix`) is registered, so it reflects the inputs of the previous clock. After reset, all outputs are 0.
- R2: When `out_valid` is 0, `out_pix` is 0, whatever pixel value was present on the input.
- R3: The column index counts valid pixels only. A valid pixel that arrives together with `in_line_sync` is column 0. A line sync with no valid pixel makes the next valid pixel column 0. A line sync discards any partial black sum.
- R4: The black window covers the columns from `cfg_blk_start` up to `cfg_blk_start`+L-1. L is 8 when `cfg_blk_len16`=0 and 16 when it is 1.
- R5: The measured level is the sum of the L window pixels shifted right by 3 (L=8) or by 4 (L=16), which is the floor of their mean.
- R6: A new measured level applies from the first valid pixel after the last window pixel. Earlier pixels of the line, including all window pixels, use the previous level.
- R7: The measured level is 0 from reset until the first window completes.
- R8: Each valid output pixel is max(input − level, 0).
- R9: When `cfg_const_en`=1, the level used is `cfg_const_lvl`. Measurement still updates in this mode, so clearing `cfg_const_en` immediately applies the most recent measured level.
- R10: `in_frame_sync` only travels through to `out_frame_sync` and leaves the measured level and column count unchanged.
- R11: Cycles with `in_valid`=0 between pixels do not advance the column index and do not add to the black sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_line_sync | input | 1 | Start-of-line pulse |
| in_frame_sync | input | 1 | Start-of-frame pulse |
| in_pix | input | PIX_W (12) | Raw pixel value |
| cfg_blk_start | input | COL_W (13) | First column of the black window |
| cfg_blk_len16 | input | 1 | 0: 8-pixel window, 1: 16-pixel window |
| cfg_const_en | input | 1 | Use the constant level instead of the measured level |
| cfg_const_lvl | input | PIX_W (12) | Constant black level |
| out_valid | output | 1 | Delayed pixel qualifier |
| out_line_sync | output | 1 | Delayed line pulse |
| out_frame_sync | output | 1 | Delayed frame pulse |
| out_pix | output | PIX_W (12) | Black-corrected pixel |

## Verification
If the column counter is wrong, the window lands on the wrong columns. The pixels just after the window then come out offset by the wrong level, and this shows within one line. A stale or uncleared accumulator leaves a visibly wrong level on the first pixel after the window closes. Wrong switch-over timing changes the value of the last window pixel or of the pixel just after it, and this is seen one clock after that pixel enters. Faults in constant mode or in the saturation logic show on the very next output pixel.

// File: rtl/blc_pkg.sv
package blc_pkg;

    // Length of the black reference window
    typedef enum logic {
        BLK_LEN_8  = 1'b0,
        BLK_LEN_16 = 1'b1
    } blk_len_e;

    // Right shift that turns a window sum into its mean
    function automatic int unsigned blk_shift(input blk_len_e len);
        return (len == BLK_LEN_16) ? 4 : 3;
    endfunction

    // Number of pixels in the window
    function automatic int unsigned blk_count(input blk_len_e len);
        return (len == BLK_LEN_16) ? 16 : 8;
    endfunction

endpackage

// File: rtl/blc_col_ctr.sv
module blc_col_ctr #(
    parameter int COL_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_line_sync,
    output logic [COL_W-1:0] col_idx
);

    localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};

    typedef struct packed {
        logic [COL_W-1:0] col;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic [COL_W-1:0] col_now;

    always_comb begin
        st_d    = st_q;
        // a line pulse makes the pixel of this very cycle column 0
        col_now = in_line_sync ? '0 : st_q.col;
        st_d.col = col_now;
        if (in_valid) begin
            st_d.col = (col_now == COL_MAX) ? COL_MAX : col_now + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_idx = col_now;

endmodule

// File: rtl/blc_black_est.sv
module blc_black_est
    import blc_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int COL_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_line_sync,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [COL_W-1:0] col_idx,
    input  logic [COL_W-1:0] win_start,
    input  logic             win_len16,
    output logic [PIX_W-1:0] meas_lvl
);

    // 16 pixels at most, so 4 extra bits of headroom
    localparam int ACC_W = PIX_W + 4;
    localparam int EXT_W = COL_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PIX_W-1:0] lvl;
    } est_st_t;

    est_st_t st_d, st_q;

    blk_len_e         len_sel;
    logic [EXT_W-1:0] win_lo;
    logic [EXT_W-1:0] win_hi;
    logic [EXT_W-1:0] col_ext;
    logic             in_win;
    logic             win_last;
    logic [ACC_W-1:0] acc_base;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] mean;

    always_comb begin
        len_sel  = blk_len_e'(win_len16);
        win_lo   = {1'b0, win_start};
        win_hi   = win_lo + EXT_W'(blk_count(len_sel));
        col_ext  = {1'b0, col_idx};
        in_win   = in_valid && (col_ext >= win_lo) && (col_ext < win_hi);
        win_last = in_valid && (col_ext == win_hi - 1'b1);

        // a new line throws away any partial sum
        acc_base = in_line_sync ? '0 : st_q.acc;
        acc_sum  = acc_base + ACC_W'(in_pix);
        mean     = acc_sum >> blk_shift(len_sel);

        st_d     = st_q;
        st_d.acc = acc_base;
        if (in_win) begin
            st_d.acc = acc_sum;
        end
        if (win_last) begin
            st_d.lvl = PIX_W'(mean);
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign meas_lvl = st_q.lvl;

endmodule

// File: rtl/blc_sub.sv
module blc_sub #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_line_sync,
    input  logic             in_frame_sync,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0] level,
    output logic             out_valid,
    output logic             out_line_sync,
    output logic             out_frame_sync,
    output logic [PIX_W-1:0] out_pix
);

    typedef struct packed {
        logic             vld;
        logic             lsync;
        logic             fsync;
        logic [PIX_W-1:0] pix;
    } sub_st_t;

    sub_st_t      st_d, st_q;
    logic [PIX_W:0] diff;

    always_comb begin
        diff       = {1'b0, in_pix} - {1'b0, level};
        st_d       = '0;
        st_d.vld   = in_valid;
        st_d.lsync = in_line_sync;
        st_d.fsync = in_frame_sync;
        if (in_valid) begin
            // borrow out means the pixel was darker than the level
            st_d.pix = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.vld;
    assign out_line_sync  = st_q.lsync;
    assign out_frame_sync = st_q.fsync;
    assign out_pix        = st_q.pix;

endmodule

// File: rtl/pix_black_clamp.sv
module pix_black_clamp #(
    parameter int PIX_W = 12,
    parameter int COL_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_line_sync,
    input  logic             in_frame_sync,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [COL_W-1:0] cfg_blk_start,
    input  logic             cfg_blk_len16,
    input  logic             cfg_const_en,
    input  logic [PIX_W-1:0] cfg_const_lvl,
    output logic             out_valid,
    output logic             out_line_sync,
    output logic             out_frame_sync,
    output logic [PIX_W-1:0] out_pix
);

    logic [COL_W-1:0] col_idx;
    logic [PIX_W-1:0] meas_lvl;
    logic [PIX_W-1:0] use_lvl;

    blc_col_ctr #(
        .COL_W(COL_W)
    ) col_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_line_sync(in_line_sync),
        .col_idx     (col_idx)
    );

    blc_black_est #(
        .PIX_W(PIX_W),
        .COL_W(COL_W)
    ) est_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_line_sync(in_line_sync),
        .in_pix      (in_pix),
        .col_idx     (col_idx),
        .win_start   (cfg_blk_start),
        .win_len16   (cfg_blk_len16),
        .meas_lvl    (meas_lvl)
    );

    always_comb begin
        use_lvl = cfg_const_en ? cfg_const_lvl : meas_lvl;
    end

    blc_sub #(
        .PIX_W(PIX_W)
    ) sub_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_line_sync  (in_line_sync),
        .in_frame_sync (in_frame_sync),
        .in_pix        (in_pix),
        .level         (use_lvl),
        .out_valid     (out_valid),
        .out_line_sync (out_line_sync),
        .out_frame_sync(out_frame_sync),
        .out_pix       (out_pix)
    );

endmodule

// File: rtl/pix_black_clamp_chk.sv
module pix_black_clamp_chk #(
    parameter int PIX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_line_sync,
    input logic             in_frame_sync,
    input logic [PIX_W-1:0] in_pix,
    input logic             cfg_const_en,
    input logic [PIX_W-1:0] cfg_const_lvl,
    input logic             out_valid,
    input logic             out_line_sync,
    input logic             out_frame_sync,
    input logic [PIX_W-1:0] out_pix
);

    // one edge must have passed since reset before $past is meaningful
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        out_valid == $past(in_valid));

    a_r1_sync_pass: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (out_line_sync == $past(in_line_sync)) && (out_frame_sync == $past(in_frame_sync)));

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_pix == '0));

    a_r8_no_growth: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(in_valid) |-> (out_pix <= $past(in_pix)));

    a_r9_const_sub: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(in_valid && cfg_const_en && (in_pix >= cfg_const_lvl))
        |-> (out_pix == $past(in_pix - cfg_const_lvl)));

    a_r9_const_floor: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(in_valid && cfg_const_en && (in_pix < cfg_const_lvl))
        |-> (out_pix == '0));

endmodule

bind pix_black_clamp pix_black_clamp_chk #(
    .PIX_W(PIX_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_line_sync  (in_line_sync),
    .in_frame_sync (in_frame_sync),
    .in_pix        (in_pix),
    .cfg_const_en  (cfg_const_en),
    .cfg_const_lvl (cfg_const_lvl),
    .out_valid     (out_valid),
    .out_line_sync (out_line_sync),
    .out_frame_sync(out_frame_sync),
    .out_pix       (out_pix)
);

// File: tb/pix_black_clamp_tb_top.sv
module pix_black_clamp_tb_top;

    localparam int PIX_W = 12;
    localparam int COL_W = 13;
    // row: start, len16, black base, probe pixel, expected probe output, gapped
    localparam int NROW = 6;
    localparam logic [95:0] TBL [NROW] = '{
        {16'd2, 16'd0, 16'd100,  16'd500,  16'd399, 16'd0},
        {16'd0, 16'd1, 16'd64,   16'd1000, 16'd935, 16'd0},
        {16'd5, 16'd0, 16'd300,  16'd200,  16'd0,   16'd1},
        {16'd3, 16'd1, 16'd4000, 16'd4095, 16'd94,  16'd0},
        {16'd1, 16'd0, 16'd0,    16'd1,    16'd0,   16'd0},
        {16'd7, 16'd1, 16'd50,   16'd52,   16'd1,   16'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_line_sync = 1'b0;
    logic             in_frame_sync = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic [COL_W-1:0] cfg_blk_start = '0;
    logic             cfg_blk_len16 = 1'b0;
    logic             cfg_const_en = 1'b0;
    logic [PIX_W-1:0] cfg_const_lvl = '0;
    logic             out_valid;
    logic             out_line_sync;
    logic             out_frame_sync;
    logic [PIX_W-1:0] out_pix;

    int total = 0;
    int bad   = 0;
    int prev_lvl = 0;

    always #5 clk = ~clk;

    pix_black_clamp #(.PIX_W(PIX_W), .COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line_sync(in_line_sync),
        .in_frame_sync(in_frame_sync), .in_pix(in_pix), .cfg_blk_start(cfg_blk_start),
        .cfg_blk_len16(cfg_blk_len16), .cfg_const_en(cfg_const_en),
        .cfg_const_lvl(cfg_const_lvl), .out_valid(out_valid),
        .out_line_sync(out_line_sync), .out_frame_sync(out_frame_sync), .out_pix(out_pix)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int a, input int b);
        return (a > b) ? a - b : 0;
    endfunction

    // drive one cycle at the falling edge, sample just after the rising edge
    task automatic cyc(input logic v, input logic ls, input logic fs, input int p,
                       output int op);
        @(negedge clk);
        in_valid = v; in_line_sync = ls; in_frame_sync = fs; in_pix = PIX_W'(p);
        @(posedge clk);
        #1;
        op = int'(out_pix);
        chk(out_valid == v && out_line_sync == ls && out_frame_sync == fs, "R1",
            {out_valid, out_line_sync, out_frame_sync}, {v, ls, fs});
        if (!v) chk(out_pix == '0, "R2 idle output", op, 0);
    endtask

    task automatic idle();
        int o;
        cyc(1'b0, 1'b0, 1'b0, 3000, o);
    endtask

    task automatic run_line(input int start, input int len16, input int base,
                            input int probe, input int exp_probe, input int gap);
        int n;
        int o;
        n = len16 ? 16 : 8;
        @(negedge clk);
        cfg_blk_start = COL_W'(start);
        cfg_blk_len16 = len16[0];
        // R3: a lone line pulse in gapped mode, the next valid pixel is column 0
        if (gap != 0) cyc(1'b0, 1'b1, 1'b0, 4095, o);
        for (int c = 0; c < start + n + 2; c++) begin
            int val;
            logic ls;
            if (c < start) val = 2000;
            else if (c < start + n) val = base + ((c - start) & 3);
            else val = probe;
            ls = (c == 0 && gap == 0);
            cyc(1'b1, ls, 1'b0, val, o);
            if (c < start)
                chk(o == sat(val, prev_lvl), "R4 pre-window pixel", o, sat(val, prev_lvl));
            else if (c < start + n)
                chk(o == sat(val, prev_lvl), "R6 window pixel uses old level", o,
                    sat(val, prev_lvl));
            else
                chk(o == exp_probe, "R5 R8 new level applied", o, exp_probe);
            // R11: idle cycles between pixels must not count
            if (gap != 0) idle();
        end
        prev_lvl = base + 1;
    endtask

    initial begin
        int o;
        // reset state (R1)
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0 && out_pix == '0, "R1 reset state", int'(out_pix), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: level is 0 before any measurement
        cfg_blk_start = 13'd100;
        cyc(1'b1, 1'b1, 1'b0, 900, o);
        chk(o == 900, "R7 level zero after reset", o, 900);

        // table walk
        for (int r = 0; r < NROW; r++) begin
            run_line(int'(TBL[r][95:80]), int'(TBL[r][79:64]), int'(TBL[r][63:48]),
                     int'(TBL[r][47:32]), int'(TBL[r][31:16]), int'(TBL[r][15:0]));
        end

        // R10: frame pulse leaves the level alone (level 51, window at 7)
        cyc(1'b1, 1'b1, 1'b1, 700, o);
        chk(o == 649, "R10 frame sync keeps level", o, 649);
        cyc(1'b1, 1'b0, 1'b0, 700, o);
        chk(o == 649, "R10 level after frame sync", o, 649);

        // R9: constant level
        @(negedge clk);
        cfg_const_en = 1'b1;
        cfg_const_lvl = 12'd200;
        cyc(1'b1, 1'b0, 1'b0, 1000, o);
        chk(o == 800, "R9 constant subtract", o, 800);
        cyc(1'b1, 1'b0, 1'b0, 150, o);
        chk(o == 0, "R9 R8 constant saturates", o, 0);
        // measure a line in constant mode: window 0..7 with base 10, level 11
        @(negedge clk);
        cfg_blk_start = '0;
        cfg_blk_len16 = 1'b0;
        for (int c = 0; c < 8; c++) begin
            cyc(1'b1, c == 0, 1'b0, 10 + (c & 3), o);
        end
        cyc(1'b1, 1'b0, 1'b0, 500, o);
        chk(o == 300, "R9 constant still used", o, 300);
        @(negedge clk);
        cfg_const_en = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 500, o);
        chk(o == 489, "R9 measurement continued", o, 489);

        // R3: a new line pulse discards a partial window sum
        @(negedge clk);
        cfg_blk_start = 13'd2;
        cyc(1'b1, 1'b1, 1'b0, 2000, o);
        cyc(1'b1, 1'b0, 1'b0, 2000, o);
        for (int c = 0; c < 3; c++) cyc(1'b1, 1'b0, 1'b0, 4000, o);
        cyc(1'b1, 1'b1, 1'b0, 2000, o);
        cyc(1'b1, 1'b0, 1'b0, 2000, o);
        for (int c = 0; c < 8; c++) cyc(1'b1, 1'b0, 1'b0, 40, o);
        cyc(1'b1, 1'b0, 1'b0, 100, o);
        chk(o == 60, "R3 line sync clears partial sum", o, 60);

        // R7 again after a second reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_pix == '0, "R1 reset clears outputs", int'(out_pix), 0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b0, 77, o);
        chk(o == 77, "R7 level cleared by reset", o, 77);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(10 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule